// File: doc/BRIEF.md
# Parallel-Shift Price Level Book

This block keeps a depth-limited, level-based order book for each of a set of instruments. Each side of each book has a fixed number of price level slots. Each slot holds a price and an aggregate quantity. Slot 0 is the best level. A slot with quantity zero is empty. All book state sits in flip-flops.

An upstream decoder presents at most one level command per clock. A command names an instrument, a side, a slot position, an action, a price and a quantity. An insert or a removal moves every deeper slot of that side in the same cycle, so the engine takes a command on every clock with no stall.

After every applied command, the engine presents the top of book for that instrument, with best bid, best ask and spread. A separate query port returns the full snapshot of any book one cycle after it is asked, while commands keep arriving.

Top module: `lvl_book_engine`

## Requirements
- R1: After reset, every slot of every book reads price 0 and quantity 0, and `tob_valid`, `upd_err` and `qry_ack` are low.
- R2: Action code 0 (insert) at slot k writes the given price and quantity into slot k and moves the old slots k..DEPTH-2 one slot deeper. The old deepest slot is discarded and slots above k keep their contents. The whole book is updated in the cycle the command is taken.
- R3: Action code 2 (remove) at slot k moves the old slots k+1..DEPTH-1 one slot shallower, sets the deepest slot to price 0 and quantity 0, and leaves slots above k untouched.
- R4: Action code 1 (modify) at slot k overwrites the price and quantity of slot k only. No other slot changes.
- R5: A command is dropped and the book is left unchanged when any of these holds: its slot position is DEPTH or more, its action code is 3, or its instrument index is NUM_BOOKS or more. For a dropped command `upd_err` is high for exactly the next cycle and `tob_valid` stays low.
- R6: One cycle after an applied command, `tob_valid` is high for one cycle. `tob_book` carries the command's instrument, and the `tob_*` price and quantity outputs carry slot 0 of both sides of that book after the command.
- R7: `tob_spread_ok` is 1 and `tob_spread` equals ask price minus bid price (modulo 2^PRICE_W) when both best slots have non-zero quantity. Otherwise `tob_spread_ok` is 0 and `tob_spread` is 0.
- R8: A query (`qry_valid` with `qry_book`) raises `qry_ack` for one cycle on the next cycle and presents all slots of both sides, with slot i at bits [i*W +: W]. A command to the same book in the same cycle is not reflected in that snapshot.
- R9: Commands issued on consecutive clocks are all applied in order, each building on the result of the previous one, with no gap required.
- R10: A command to one instrument leaves every other instrument's book unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_valid | input | 1 | Level command present |
| upd_book | input | BOOK_W | Instrument index |
| upd_side | input | 1 | 0 bid, 1 ask |
| upd_pos | input | POS_W | Slot position, 0 is best |
| upd_act | input | 2 | 0 insert, 1 modify, 2 remove, 3 reserved |
| upd_price | input | PRICE_W | Level price |
| upd_qty | input | QTY_W | Level aggregate quantity |
| qry_valid | input | 1 | Snapshot request |
| qry_book | input | BOOK_W | Instrument to read |
| qry_ack | output | 1 | Snapshot outputs valid |
| qry_bid_px | output | DEPTH*PRICE_W | Bid prices, slot i at [i*PRICE_W +: PRICE_W] |
| qry_bid_qty | output | DEPTH*QTY_W | Bid quantities |
| qry_ask_px | output | DEPTH*PRICE_W | Ask prices |
| qry_ask_qty | output | DEPTH*QTY_W | Ask quantities |
| upd_err | output | 1 | Dropped-command pulse |
| tob_valid | output | 1 | Top-of-book record valid |
| tob_book | output | BOOK_W | Instrument of the record |
| tob_bid_px | output | PRICE_W | Best bid price |
| tob_bid_qty | output | QTY_W | Best bid quantity |
| tob_ask_px | output | PRICE_W | Best ask price |
| tob_ask_qty | output | QTY_W | Best ask quantity |
| tob_spread | output | PRICE_W | Ask minus bid |
| tob_spread_ok | output | 1 | Both best slots non-empty |

## Verification
The bench builds the engine with three instruments, four slots per side and 16-bit prices and quantities. With four slots, a side fills within a few commands, so the bench reaches a discard of the deepest slot on insert and a clear of the deepest slot on remove. With three instruments against a two-bit index, an index that addresses no book can be driven. A three-bit slot field leaves positions 4 to 7 free to exercise the out-of-range drop.

// File: rtl/lob_pkg.sv
package lob_pkg;
   typedef enum logic [1:0] {
      ACT_INS = 2'd0,
      ACT_MOD = 2'd1,
      ACT_REM = 2'd2,
      ACT_RSV = 2'd3
   } lob_act_e;

   localparam logic SIDE_BID = 1'b0;
   localparam logic SIDE_ASK = 1'b1;
endpackage

// File: rtl/lvl_shift_unit.sv
module lvl_shift_unit
   import lob_pkg::*;
#(
   parameter int DEPTH   = 10,
   parameter int PRICE_W = 32,
   parameter int QTY_W   = 32,
   parameter int POS_W   = 5
) (
   input  logic [DEPTH-1:0][PRICE_W-1:0] cur_px,
   input  logic [DEPTH-1:0][QTY_W-1:0]   cur_qty,
   input  lob_act_e                      act,
   input  logic [POS_W-1:0]              pos,
   input  logic [PRICE_W-1:0]            in_px,
   input  logic [QTY_W-1:0]              in_qty,
   output logic [DEPTH-1:0][PRICE_W-1:0] nxt_px,
   output logic [DEPTH-1:0][QTY_W-1:0]   nxt_qty
);
   for (genvar i = 0; i < DEPTH; i++) begin : g_lvl
      localparam logic [POS_W-1:0] IDX = POS_W'(i);
      logic [PRICE_W-1:0] shal_px, deep_px, px_d;
      logic [QTY_W-1:0]   shal_qty, deep_qty, qty_d;

      if (i == 0) begin : g_top
         assign shal_px  = '0;
         assign shal_qty = '0;
      end else begin : g_inner_up
         assign shal_px  = cur_px[i-1];
         assign shal_qty = cur_qty[i-1];
      end

      if (i == DEPTH - 1) begin : g_bottom
         assign deep_px  = '0;
         assign deep_qty = '0;
      end else begin : g_inner_dn
         assign deep_px  = cur_px[i+1];
         assign deep_qty = cur_qty[i+1];
      end

      always_comb begin
         px_d  = cur_px[i];
         qty_d = cur_qty[i];
         case (act)
            ACT_INS: begin
               if (pos == IDX) begin
                  px_d  = in_px;
                  qty_d = in_qty;
               end else if (pos < IDX) begin
                  px_d  = shal_px;
                  qty_d = shal_qty;
               end
            end
            ACT_MOD: begin
               if (pos == IDX) begin
                  px_d  = in_px;
                  qty_d = in_qty;
               end
            end
            ACT_REM: begin
               if (pos <= IDX) begin
                  px_d  = deep_px;
                  qty_d = deep_qty;
               end
            end
            default: ;
         endcase
      end

      assign nxt_px[i]  = px_d;
      assign nxt_qty[i] = qty_d;
   end
endmodule

// File: rtl/lvl_tob_calc.sv
module lvl_tob_calc #(
   parameter int PRICE_W = 32,
   parameter int QTY_W   = 32
) (
   input  logic [PRICE_W-1:0] bid_px,
   input  logic [QTY_W-1:0]   bid_qty,
   input  logic [PRICE_W-1:0] ask_px,
   input  logic [QTY_W-1:0]   ask_qty,
   output logic [PRICE_W-1:0] spread,
   output logic               spread_ok
);
   logic both_live;

   assign both_live = (bid_qty != '0) && (ask_qty != '0);
   assign spread_ok = both_live;
   assign spread    = both_live ? (ask_px - bid_px) : '0;
endmodule

// File: rtl/lvl_book_engine.sv
module lvl_book_engine
   import lob_pkg::*;
#(
   parameter int NUM_BOOKS = 8,
   parameter int DEPTH     = 10,
   parameter int PRICE_W   = 32,
   parameter int QTY_W     = 32,
   parameter int BOOK_W    = (NUM_BOOKS > 1) ? $clog2(NUM_BOOKS) : 1,
   parameter int POS_W     = $clog2(DEPTH) + 1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       upd_valid,
   input  logic [BOOK_W-1:0]          upd_book,
   input  logic                       upd_side,
   input  logic [POS_W-1:0]           upd_pos,
   input  logic [1:0]                 upd_act,
   input  logic [PRICE_W-1:0]         upd_price,
   input  logic [QTY_W-1:0]           upd_qty,
   input  logic                       qry_valid,
   input  logic [BOOK_W-1:0]          qry_book,
   output logic                       qry_ack,
   output logic [DEPTH*PRICE_W-1:0]   qry_bid_px,
   output logic [DEPTH*QTY_W-1:0]     qry_bid_qty,
   output logic [DEPTH*PRICE_W-1:0]   qry_ask_px,
   output logic [DEPTH*QTY_W-1:0]     qry_ask_qty,
   output logic                       upd_err,
   output logic                       tob_valid,
   output logic [BOOK_W-1:0]          tob_book,
   output logic [PRICE_W-1:0]         tob_bid_px,
   output logic [QTY_W-1:0]           tob_bid_qty,
   output logic [PRICE_W-1:0]         tob_ask_px,
   output logic [QTY_W-1:0]           tob_ask_qty,
   output logic [PRICE_W-1:0]         tob_spread,
   output logic                       tob_spread_ok
);
   localparam logic [POS_W-1:0]  DEPTH_P = POS_W'(DEPTH);
   localparam logic [BOOK_W:0]   BOOKS_P = (BOOK_W + 1)'(NUM_BOOKS);

   if (DEPTH < 2) begin : g_bad_depth
      $error("lvl_book_engine: DEPTH must be at least 2");
   end
   if (NUM_BOOKS < 1) begin : g_bad_books
      $error("lvl_book_engine: NUM_BOOKS must be at least 1");
   end
   if (POS_W < $clog2(DEPTH + 1)) begin : g_bad_pos_w
      $error("lvl_book_engine: POS_W too narrow to flag out-of-range slots");
   end
   if ((1 << BOOK_W) < NUM_BOOKS) begin : g_bad_book_w
      $error("lvl_book_engine: BOOK_W too narrow for NUM_BOOKS");
   end

   typedef logic [DEPTH-1:0][PRICE_W-1:0] px_side_t;
   typedef logic [DEPTH-1:0][QTY_W-1:0]   qty_side_t;

   px_side_t  bid_px_q  [NUM_BOOKS];
   qty_side_t bid_qty_q [NUM_BOOKS];
   px_side_t  ask_px_q  [NUM_BOOKS];
   qty_side_t ask_qty_q [NUM_BOOKS];

   // command qualification
   logic              pos_ok, act_ok, book_ok, cmd_apply, cmd_drop;
   logic [BOOK_W-1:0] upd_idx;

   assign pos_ok    = upd_pos < DEPTH_P;
   assign act_ok    = upd_act != 2'(ACT_RSV);
   assign book_ok   = {1'b0, upd_book} < BOOKS_P;
   assign cmd_apply = upd_valid && pos_ok && act_ok && book_ok;
   assign cmd_drop  = upd_valid && !(pos_ok && act_ok && book_ok);
   assign upd_idx   = book_ok ? upd_book : '0;

   // one side of one book goes through the parallel shifter
   px_side_t  cur_px, nxt_px;
   qty_side_t cur_qty, nxt_qty;

   assign cur_px  = (upd_side == SIDE_ASK) ? ask_px_q[upd_idx]  : bid_px_q[upd_idx];
   assign cur_qty = (upd_side == SIDE_ASK) ? ask_qty_q[upd_idx] : bid_qty_q[upd_idx];

   lvl_shift_unit #(
      .DEPTH   (DEPTH),
      .PRICE_W (PRICE_W),
      .QTY_W   (QTY_W),
      .POS_W   (POS_W)
   ) u_shift (
      .cur_px  (cur_px),
      .cur_qty (cur_qty),
      .act     (lob_act_e'(upd_act)),
      .pos     (upd_pos),
      .in_px   (upd_price),
      .in_qty  (upd_qty),
      .nxt_px  (nxt_px),
      .nxt_qty (nxt_qty)
   );

   // book storage
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int b = 0; b < NUM_BOOKS; b++) begin
            bid_px_q[b]  <= '0;
            bid_qty_q[b] <= '0;
            ask_px_q[b]  <= '0;
            ask_qty_q[b] <= '0;
         end
      end else if (cmd_apply) begin
         if (upd_side == SIDE_ASK) begin
            ask_px_q[upd_idx]  <= nxt_px;
            ask_qty_q[upd_idx] <= nxt_qty;
         end else begin
            bid_px_q[upd_idx]  <= nxt_px;
            bid_qty_q[upd_idx] <= nxt_qty;
         end
      end
   end

   // top of book after the command
   logic [PRICE_W-1:0] new_bid_px, new_ask_px, new_spread;
   logic [QTY_W-1:0]   new_bid_qty, new_ask_qty;
   logic               new_spread_ok;

   assign new_bid_px  = (upd_side == SIDE_BID) ? nxt_px[0]  : bid_px_q[upd_idx][0];
   assign new_bid_qty = (upd_side == SIDE_BID) ? nxt_qty[0] : bid_qty_q[upd_idx][0];
   assign new_ask_px  = (upd_side == SIDE_ASK) ? nxt_px[0]  : ask_px_q[upd_idx][0];
   assign new_ask_qty = (upd_side == SIDE_ASK) ? nxt_qty[0] : ask_qty_q[upd_idx][0];

   lvl_tob_calc #(
      .PRICE_W (PRICE_W),
      .QTY_W   (QTY_W)
   ) u_tob (
      .bid_px    (new_bid_px),
      .bid_qty   (new_bid_qty),
      .ask_px    (new_ask_px),
      .ask_qty   (new_ask_qty),
      .spread    (new_spread),
      .spread_ok (new_spread_ok)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tob_valid     <= 1'b0;
         upd_err       <= 1'b0;
         tob_book      <= '0;
         tob_bid_px    <= '0;
         tob_bid_qty   <= '0;
         tob_ask_px    <= '0;
         tob_ask_qty   <= '0;
         tob_spread    <= '0;
         tob_spread_ok <= 1'b0;
      end else begin
         tob_valid <= cmd_apply;
         upd_err   <= cmd_drop;
         if (cmd_apply) begin
            tob_book      <= upd_book;
            tob_bid_px    <= new_bid_px;
            tob_bid_qty   <= new_bid_qty;
            tob_ask_px    <= new_ask_px;
            tob_ask_qty   <= new_ask_qty;
            tob_spread    <= new_spread;
            tob_spread_ok <= new_spread_ok;
         end
      end
   end

   // snapshot read: samples the registers before this edge's write lands
   logic              qry_ok;
   logic [BOOK_W-1:0] qry_idx;
   px_side_t          snap_bid_px, snap_ask_px;
   qty_side_t         snap_bid_qty, snap_ask_qty;

   assign qry_ok  = {1'b0, qry_book} < BOOKS_P;
   assign qry_idx = qry_ok ? qry_book : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         qry_ack      <= 1'b0;
         snap_bid_px  <= '0;
         snap_bid_qty <= '0;
         snap_ask_px  <= '0;
         snap_ask_qty <= '0;
      end else begin
         qry_ack <= qry_valid;
         if (qry_valid) begin
            snap_bid_px  <= qry_ok ? bid_px_q[qry_idx]  : '0;
            snap_bid_qty <= qry_ok ? bid_qty_q[qry_idx] : '0;
            snap_ask_px  <= qry_ok ? ask_px_q[qry_idx]  : '0;
            snap_ask_qty <= qry_ok ? ask_qty_q[qry_idx] : '0;
         end
      end
   end

   assign qry_bid_px  = snap_bid_px;
   assign qry_bid_qty = snap_bid_qty;
   assign qry_ask_px  = snap_ask_px;
   assign qry_ask_qty = snap_ask_qty;
endmodule

// File: rtl/lvl_book_engine_chk.sv
module lvl_book_engine_chk #(
   parameter int NUM_BOOKS = 8,
   parameter int DEPTH     = 10,
   parameter int PRICE_W   = 32,
   parameter int QTY_W     = 32,
   parameter int BOOK_W    = 3,
   parameter int POS_W     = 5
) (
   input logic               clk,
   input logic               rst_n,
   input logic               upd_valid,
   input logic [BOOK_W-1:0]  upd_book,
   input logic               upd_side,
   input logic [POS_W-1:0]   upd_pos,
   input logic [1:0]         upd_act,
   input logic [PRICE_W-1:0] upd_price,
   input logic [QTY_W-1:0]   upd_qty,
   input logic               qry_valid,
   input logic               qry_ack,
   input logic               upd_err,
   input logic               tob_valid,
   input logic [BOOK_W-1:0]  tob_book,
   input logic [PRICE_W-1:0] tob_bid_px,
   input logic [QTY_W-1:0]   tob_bid_qty,
   input logic [PRICE_W-1:0] tob_ask_px,
   input logic [QTY_W-1:0]   tob_ask_qty,
   input logic [PRICE_W-1:0] tob_spread,
   input logic               tob_spread_ok
);
   localparam logic [POS_W-1:0] DEPTH_P = POS_W'(DEPTH);
   localparam logic [BOOK_W:0]  BOOKS_P = (BOOK_W + 1)'(NUM_BOOKS);

   logic good_cmd;
   assign good_cmd = upd_valid && (upd_pos < DEPTH_P) && (upd_act != 2'd3)
                     && ({1'b0, upd_book} < BOOKS_P);

   AST_BAD_POS_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
      upd_valid && (upd_pos >= DEPTH_P) |=> upd_err && !tob_valid); // R5

   AST_RSV_ACT_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
      upd_valid && (upd_act == 2'd3) |=> upd_err && !tob_valid); // R5

   AST_ERR_TOB_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({upd_err, tob_valid})); // R5

   AST_TOB_FOLLOWS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      good_cmd |=> tob_valid && (tob_book == $past(upd_book))); // R6

   AST_INS_TOP_BID: assert property (@(posedge clk) disable iff (!rst_n)
      good_cmd && (upd_act == 2'd0) && (upd_pos == '0) && !upd_side
      |=> (tob_bid_px == $past(upd_price)) && (tob_bid_qty == $past(upd_qty))); // R2

   AST_INS_TOP_ASK: assert property (@(posedge clk) disable iff (!rst_n)
      good_cmd && (upd_act == 2'd0) && (upd_pos == '0) && upd_side
      |=> (tob_ask_px == $past(upd_price)) && (tob_ask_qty == $past(upd_qty))); // R2

   AST_MOD_TOP_ASK: assert property (@(posedge clk) disable iff (!rst_n)
      good_cmd && (upd_act == 2'd1) && (upd_pos == '0) && upd_side
      |=> tob_ask_qty == $past(upd_qty)); // R4

   AST_SPREAD_EMPTY_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
      tob_valid && ((tob_bid_qty == '0) || (tob_ask_qty == '0))
      |-> !tob_spread_ok && (tob_spread == '0)); // R7

   AST_QRY_ACK_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      qry_valid |=> qry_ack); // R8

   AST_QRY_ACK_ONLY_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      !qry_valid |=> !qry_ack); // R8
endmodule

bind lvl_book_engine lvl_book_engine_chk #(
   .NUM_BOOKS (NUM_BOOKS),
   .DEPTH     (DEPTH),
   .PRICE_W   (PRICE_W),
   .QTY_W     (QTY_W),
   .BOOK_W    (BOOK_W),
   .POS_W     (POS_W)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .upd_valid     (upd_valid),
   .upd_book      (upd_book),
   .upd_side      (upd_side),
   .upd_pos       (upd_pos),
   .upd_act       (upd_act),
   .upd_price     (upd_price),
   .upd_qty       (upd_qty),
   .qry_valid     (qry_valid),
   .qry_ack       (qry_ack),
   .upd_err       (upd_err),
   .tob_valid     (tob_valid),
   .tob_book      (tob_book),
   .tob_bid_px    (tob_bid_px),
   .tob_bid_qty   (tob_bid_qty),
   .tob_ask_px    (tob_ask_px),
   .tob_ask_qty   (tob_ask_qty),
   .tob_spread    (tob_spread),
   .tob_spread_ok (tob_spread_ok)
);

// File: tb/lvl_book_engine_tb.sv
`timescale 1ns/1ps
module lvl_book_engine_tb;
   localparam int NB = 3;
   localparam int D  = 4;
   localparam int PW = 16;
   localparam int QW = 16;
   localparam int BW = 2;
   localparam int SW = 3;
   localparam int VW = BW + 1 + SW + 2 + PW + QW;

   logic               clk = 1'b0;
   logic               rst_n;
   logic               upd_valid;
   logic [BW-1:0]      upd_book;
   logic               upd_side;
   logic [SW-1:0]      upd_pos;
   logic [1:0]         upd_act;
   logic [PW-1:0]      upd_price;
   logic [QW-1:0]      upd_qty;
   logic               qry_valid;
   logic [BW-1:0]      qry_book;
   logic               qry_ack;
   logic [D*PW-1:0]    qry_bid_px, qry_ask_px;
   logic [D*QW-1:0]    qry_bid_qty, qry_ask_qty;
   logic               upd_err, tob_valid, tob_spread_ok;
   logic [BW-1:0]      tob_book;
   logic [PW-1:0]      tob_bid_px, tob_ask_px, tob_spread;
   logic [QW-1:0]      tob_bid_qty, tob_ask_qty;

   always #10 clk = ~clk;

   lvl_book_engine #(
      .NUM_BOOKS (NB), .DEPTH (D), .PRICE_W (PW), .QTY_W (QW),
      .BOOK_W (BW), .POS_W (SW)
   ) u_dut (
      .clk (clk), .rst_n (rst_n),
      .upd_valid (upd_valid), .upd_book (upd_book), .upd_side (upd_side),
      .upd_pos (upd_pos), .upd_act (upd_act), .upd_price (upd_price), .upd_qty (upd_qty),
      .qry_valid (qry_valid), .qry_book (qry_book), .qry_ack (qry_ack),
      .qry_bid_px (qry_bid_px), .qry_bid_qty (qry_bid_qty),
      .qry_ask_px (qry_ask_px), .qry_ask_qty (qry_ask_qty),
      .upd_err (upd_err), .tob_valid (tob_valid), .tob_book (tob_book),
      .tob_bid_px (tob_bid_px), .tob_bid_qty (tob_bid_qty),
      .tob_ask_px (tob_ask_px), .tob_ask_qty (tob_ask_qty),
      .tob_spread (tob_spread), .tob_spread_ok (tob_spread_ok)
   );

   // vector: {book, side, pos, act, price, qty}
   localparam logic [VW-1:0] VEC [12] = '{
      {2'd0, 1'b0, 3'd0, 2'd0, 16'd100, 16'd10},
      {2'd0, 1'b0, 3'd0, 2'd0, 16'd101, 16'd5},
      {2'd0, 1'b0, 3'd2, 2'd0, 16'd98,  16'd7},
      {2'd0, 1'b1, 3'd0, 2'd0, 16'd105, 16'd3},
      {2'd0, 1'b0, 3'd3, 2'd0, 16'd97,  16'd1},
      {2'd0, 1'b0, 3'd1, 2'd0, 16'd150, 16'd2},
      {2'd0, 1'b0, 3'd1, 2'd1, 16'd151, 16'd9},
      {2'd0, 1'b0, 3'd0, 2'd2, 16'd0,   16'd0},
      {2'd0, 1'b1, 3'd0, 2'd2, 16'd0,   16'd0},
      {2'd2, 1'b1, 3'd0, 2'd0, 16'd200, 16'd4},
      {2'd2, 1'b1, 3'd1, 2'd0, 16'd201, 16'd6},
      {2'd0, 1'b0, 3'd3, 2'd2, 16'd0,   16'd0}
   };

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;
   int mpx [NB][2][D];
   int mq  [NB][2][D];

   task automatic chk_eq(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic m_apply(input int b, input int s, input int p, input int a,
                          input int px, input int q);
      if (a == 0) begin
         for (int i = D - 1; i > p; i--) begin
            mpx[b][s][i] = mpx[b][s][i-1];
            mq[b][s][i]  = mq[b][s][i-1];
         end
         mpx[b][s][p] = px; mq[b][s][p] = q;
      end else if (a == 1) begin
         mpx[b][s][p] = px; mq[b][s][p] = q;
      end else if (a == 2) begin
         for (int i = p; i < D - 1; i++) begin
            mpx[b][s][i] = mpx[b][s][i+1];
            mq[b][s][i]  = mq[b][s][i+1];
         end
         mpx[b][s][D-1] = 0; mq[b][s][D-1] = 0;
      end
   endtask

   task automatic check_tob(input int b, input string req);
      int ok;
      chk_eq(req, "tob_valid", 64'(tob_valid), 64'd1);
      chk_eq(req, "upd_err", 64'(upd_err), 64'd0);
      chk_eq(req, "tob_book", 64'(tob_book), 64'(b));
      chk_eq(req, "tob_bid_px", 64'(tob_bid_px), 64'(mpx[b][0][0]));
      chk_eq(req, "tob_bid_qty", 64'(tob_bid_qty), 64'(mq[b][0][0]));
      chk_eq(req, "tob_ask_px", 64'(tob_ask_px), 64'(mpx[b][1][0]));
      chk_eq(req, "tob_ask_qty", 64'(tob_ask_qty), 64'(mq[b][1][0]));
      ok = (mq[b][0][0] != 0 && mq[b][1][0] != 0) ? 1 : 0;
      chk_eq("R7", "tob_spread_ok", 64'(tob_spread_ok), 64'(ok));
      chk_eq("R7", "tob_spread", 64'(tob_spread),
             ok ? 64'((mpx[b][1][0] - mpx[b][0][0]) & 16'hFFFF) : 64'd0);
   endtask

   task automatic check_snap(input int b, input string req);
      chk_eq(req, "qry_ack", 64'(qry_ack), 64'd1);
      for (int i = 0; i < D; i++) begin
         chk_eq(req, $sformatf("book%0d bid px[%0d]", b, i), 64'(qry_bid_px[i*PW +: PW]), 64'(mpx[b][0][i]));
         chk_eq(req, $sformatf("book%0d bid qty[%0d]", b, i), 64'(qry_bid_qty[i*QW +: QW]), 64'(mq[b][0][i]));
         chk_eq(req, $sformatf("book%0d ask px[%0d]", b, i), 64'(qry_ask_px[i*PW +: PW]), 64'(mpx[b][1][i]));
         chk_eq(req, $sformatf("book%0d ask qty[%0d]", b, i), 64'(qry_ask_qty[i*QW +: QW]), 64'(mq[b][1][i]));
      end
   endtask

   task automatic drive(input int b, input int s, input int p, input int a,
                        input int px, input int q);
      upd_valid = 1'b1; upd_book = BW'(b); upd_side = s[0]; upd_pos = SW'(p);
      upd_act = a[1:0]; upd_price = PW'(px); upd_qty = QW'(q);
   endtask

   task automatic do_qry(input int b, input string req);
      @(negedge clk);
      qry_valid = 1'b1; qry_book = BW'(b);
      @(negedge clk);
      qry_valid = 1'b0;
      check_snap(b, req);
   endtask

   task automatic do_upd(input int b, input int s, input int p, input int a,
                         input int px, input int q, input string req);
      @(negedge clk);
      drive(b, s, p, a, px, q);
      @(negedge clk);
      upd_valid = 1'b0;
      m_apply(b, s, p, a, px, q);
      check_tob(b, req);
   endtask

   task automatic do_bad(input int b, input int s, input int p, input int a, input string req);
      @(negedge clk);
      drive(b, s, p, a, 55, 66);
      @(negedge clk);
      upd_valid = 1'b0;
      chk_eq(req, "upd_err pulse", 64'(upd_err), 64'd1);
      chk_eq(req, "tob_valid on drop", 64'(tob_valid), 64'd0);
      @(negedge clk);
      chk_eq(req, "upd_err one cycle", 64'(upd_err), 64'd0);
      if (b < NB) do_qry(b, req);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      for (int b = 0; b < NB; b++)
         for (int s = 0; s < 2; s++)
            for (int i = 0; i < D; i++) begin mpx[b][s][i] = 0; mq[b][s][i] = 0; end
      rst_n = 1'b0; upd_valid = 1'b0; upd_book = '0; upd_side = 1'b0; upd_pos = '0;
      upd_act = '0; upd_price = '0; upd_qty = '0; qry_valid = 1'b0; qry_book = '0;
      repeat (3) @(negedge clk);
      // R1 reset state of the outputs
      chk_eq("R1", "tob_valid", 64'(tob_valid), 64'd0);
      chk_eq("R1", "upd_err", 64'(upd_err), 64'd0);
      chk_eq("R1", "qry_ack", 64'(qry_ack), 64'd0);
      rst_n = 1'b1;
      for (int b = 0; b < NB; b++) do_qry(b, "R1");

      // table walk: R2 insert, R4 modify, R3 remove; tob R6 and spread R7
      for (int v = 0; v < 12; v++) begin
         logic [VW-1:0] e;
         int b, s, p, a, px, q;
         string req;
         e  = VEC[v];
         b  = int'(e[VW-1 -: BW]);
         s  = int'(e[VW-BW-1]);
         p  = int'(e[PW+QW+2 +: SW]);
         a  = int'(e[PW+QW +: 2]);
         px = int'(e[QW +: PW]);
         q  = int'(e[0 +: QW]);
         req = (a == 0) ? "R2" : (a == 1) ? "R4" : "R3";
         do_upd(b, s, p, a, px, q, "R6");
         do_qry(b, req);
      end

      // R10 book 1 untouched by traffic on books 0 and 2
      do_qry(1, "R10");

      // R5 drops: slot out of range, reserved action, missing book
      do_bad(0, 0, 4, 0, "R5");
      do_bad(2, 1, 7, 2, "R5");
      do_bad(0, 1, 0, 3, "R5");
      do_bad(3, 0, 0, 0, "R5");
      do_qry(0, "R5");

      // R9 back-to-back commands on one book
      @(negedge clk);
      drive(1, 0, 0, 0, 50, 1);
      @(negedge clk);
      drive(1, 0, 0, 0, 60, 2);
      m_apply(1, 0, 0, 0, 50, 1);
      check_tob(1, "R9");
      @(negedge clk);
      upd_valid = 1'b0;
      m_apply(1, 0, 0, 0, 60, 2);
      check_tob(1, "R9");
      do_qry(1, "R9");

      // R8 query and command to the same book in one cycle
      @(negedge clk);
      drive(1, 1, 0, 0, 70, 3);
      qry_valid = 1'b1; qry_book = 2'd1;
      @(negedge clk);
      upd_valid = 1'b0; qry_valid = 1'b0;
      check_snap(1, "R8");
      m_apply(1, 1, 0, 0, 70, 3);
      check_tob(1, "R8");
      do_qry(1, "R8");

      finish_run();
   end
endmodule